// File: doc/BRIEF.md
# Guest Event Exit Filter

This block sits between an event source in a virtualized processor and the monitor that handles exits. For every guest event offered to it, it decides in a single registered step whether the monitor must take control or whether the event can finish inside guest context. When the event finishes in the guest, the block supplies the result directly. That result is a substituted control-register value, a timestamp with an offset added, or an indication that an exception goes straight to the guest's own handler.

Configuration arrives through a simple write port. Software writes a 32-entry exception bitmap, a 65536-port I/O bitmap one 32-bit word at a time, three control-register shadow values and a 64-bit timestamp offset. Some events always exit and never consult a bitmap: external interrupts, control-register writes and other privileged-resource writes. Fast system-call entry and return never exit.

Top module: `gevt_exit_filter`

## Requirements
- R1: After reset, no result is valid and all result outputs are zero. Both bitmaps read as all clear, so every exception is delivered and no port access exits. The shadows and the timestamp offset read as zero.
- R2: An exception event (evtKind 0) takes its vector from evtCode[4:0]. If that bit of the exception bitmap is set, it exits with reason 0. If the bit is clear, resDeliver is 1 and there is no exit.
- R3: A port access (evtKind 2) looks up I/O bitmap word evtCode[15:5], bit evtCode[4:0]. A set bit exits with reason 2. A clear bit completes with no exit, no deliver and zero data.
- R4: A control-register read (evtKind 3) of register 0, 2 or 4 (the value in evtCode) returns the matching shadow on resData and does not exit. A read of any other register number exits with reason 4.
- R5: A timestamp read (evtKind 5) returns evtTsc plus the programmed offset, modulo 2^64, with no exit.
- R6: A fast system-call event (evtKind 6) never exits, never delivers and returns zero data.
- R7: An external interrupt (evtKind 1) exits with reason 1. A control-register write (evtKind 4) exits with reason 3. Any other privileged write (evtKind 7) exits with reason 4.
- R8: resValid is high in exactly the cycle after a cycle with evtValid high. In every other cycle all result outputs are zero.
- R9: Configuration writes use cfgSel as follows: 0 = exception bitmap (cfgData[31:0]), 1 = I/O word cfgAddr (cfgData[31:0]), 2/3/4 = shadow of register 0/2/4, 5 = timestamp offset. A write takes effect for events presented in later cycles. An event in the same cycle as the write sees the old value.
- R10: resCode carries the evtCode of the event that produced the result, whether or not the event exits.
- R11: resExit and resDeliver are never both high. resData is zero whenever resExit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Configuration target select |
| cfgAddr | input | 11 | I/O bitmap word index |
| cfgData | input | 64 | Configuration write data |
| evtValid | input | 1 | Guest event present |
| evtKind | input | 3 | Event type |
| evtCode | input | 16 | Vector, port number or register number |
| evtTsc | input | 64 | Physical timestamp counter |
| resValid | output | 1 | Decision valid |
| resExit | output | 1 | Event forces an exit |
| resReason | output | 3 | Exit reason code |
| resCode | output | 16 | Latched vector, port or register number |
| resDeliver | output | 1 | Exception delivered directly to the guest |
| resData | output | 64 | Shadow value or offset timestamp |

## Verification
The hardest case to reach is a configuration write that lands in the same cycle as an event depending on it, because the old and new values differ only at that one edge. The stimulus pairs a bitmap write that sets a vector with an exception on that vector in the same cycle, then repeats the exception a cycle later. Two further corners are I/O bitmap words that were never written and words at the top and bottom of the port space. These are reached with directed ports at both ends of the range, followed by a long random mix of writes and events on a small set of words. A behavioural model predicts every output on every clock.

// File: rtl/gevt_pkg.sv
package gevt_pkg;

  typedef enum logic [2:0] {
    EV_EXC     = 3'd0,
    EV_EXTINT  = 3'd1,
    EV_IO      = 3'd2,
    EV_CRRD    = 3'd3,
    EV_CRWR    = 3'd4,
    EV_TSC     = 3'd5,
    EV_SYSCALL = 3'd6,
    EV_PRIV    = 3'd7
  } evtKind_e;

  typedef enum logic [2:0] {
    RSN_EXC   = 3'd0,
    RSN_INTR  = 3'd1,
    RSN_IO    = 3'd2,
    RSN_CRWR  = 3'd3,
    RSN_OTHER = 3'd4
  } reason_e;

  typedef enum logic [2:0] {
    CFG_EXCMAP = 3'd0,
    CFG_IOWORD = 3'd1,
    CFG_SH0    = 3'd2,
    CFG_SH2    = 3'd3,
    CFG_SH4    = 3'd4,
    CFG_TSCOFS = 3'd5
  } cfgSel_e;

  typedef enum logic [1:0] {
    DSEL_ZERO   = 2'd0,
    DSEL_SHADOW = 2'd1,
    DSEL_TSC    = 2'd2
  } dataSel_e;

  localparam int NUM_SHADOW = 3;

  typedef struct packed {
    logic       load;
    logic       doExit;
    logic [2:0] reason;
    logic       deliver;
    dataSel_e   dataSel;
    logic [1:0] shIdx;
  } ctrlStrobe_t;

endpackage

// File: rtl/gevt_ctrl.sv
module gevt_ctrl
  import gevt_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic              evtValid,
  input  logic [2:0]        evtKind,
  input  logic [CODE_W-1:0] evtCode,
  input  logic              excHit,
  input  logic              ioHit,
  output ctrlStrobe_t       strobe
);

  evtKind_e kindE;
  assign kindE = evtKind_e'(evtKind);

  always_comb begin
    strobe         = '0;
    strobe.load    = evtValid;
    strobe.dataSel = DSEL_ZERO;
    if (evtValid) begin
      unique case (kindE)
        EV_EXC: begin
          if (excHit) begin
            strobe.doExit = 1'b1;
            strobe.reason = RSN_EXC;
          end else begin
            strobe.deliver = 1'b1;
          end
        end
        EV_EXTINT: begin
          strobe.doExit = 1'b1;
          strobe.reason = RSN_INTR;
        end
        EV_IO: begin
          if (ioHit) begin
            strobe.doExit = 1'b1;
            strobe.reason = RSN_IO;
          end
        end
        EV_CRRD: begin
          if (evtCode == CODE_W'(0)) begin
            strobe.dataSel = DSEL_SHADOW;
            strobe.shIdx   = 2'd0;
          end else if (evtCode == CODE_W'(2)) begin
            strobe.dataSel = DSEL_SHADOW;
            strobe.shIdx   = 2'd1;
          end else if (evtCode == CODE_W'(4)) begin
            strobe.dataSel = DSEL_SHADOW;
            strobe.shIdx   = 2'd2;
          end else begin
            strobe.doExit = 1'b1;
            strobe.reason = RSN_OTHER;
          end
        end
        EV_CRWR: begin
          strobe.doExit = 1'b1;
          strobe.reason = RSN_CRWR;
        end
        EV_TSC: begin
          strobe.dataSel = DSEL_TSC;
        end
        EV_SYSCALL: begin
          strobe.doExit = 1'b0;
        end
        EV_PRIV: begin
          strobe.doExit = 1'b1;
          strobe.reason = RSN_OTHER;
        end
        default: begin
          strobe.doExit = 1'b1;
          strobe.reason = RSN_OTHER;
        end
      endcase
    end
  end

endmodule

// File: rtl/gevt_dp.sv
module gevt_dp
  import gevt_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int PORT_W = 16,
  parameter int VEC_W  = 5,
  parameter int WORD_W = 32,
  localparam int BIT_IDX_W = $clog2(WORD_W),
  localparam int IO_ADDR_W = PORT_W - BIT_IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfgWrEn,
  input  logic [2:0]           cfgSel,
  input  logic [IO_ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0]    cfgData,
  input  logic [PORT_W-1:0]    evtCode,
  input  logic [DATA_W-1:0]    evtTsc,
  input  ctrlStrobe_t          strobe,
  output logic                 excHit,
  output logic                 ioHit,
  output logic                 resValid,
  output logic                 resExit,
  output logic [2:0]           resReason,
  output logic [PORT_W-1:0]    resCode,
  output logic                 resDeliver,
  output logic [DATA_W-1:0]    resData
);

  localparam int NUM_VEC  = 1 << VEC_W;
  localparam int IO_WORDS = 1 << IO_ADDR_W;
  localparam int SH_BASE  = int'(CFG_SH0);

  cfgSel_e selE;
  assign selE = cfgSel_e'(cfgSel);

  // Exception bitmap
  logic [NUM_VEC-1:0] excMap;
  always_ff @(posedge clk) begin
    if (!rst_n)                              excMap <= '0;
    else if (cfgWrEn && selE == CFG_EXCMAP)  excMap <= cfgData[NUM_VEC-1:0];
  end
  assign excHit = excMap[evtCode[VEC_W-1:0]];

  // I/O bitmap: word storage without reset, one live bit per word
  logic [WORD_W-1:0]   ioMem [IO_WORDS];
  logic [IO_WORDS-1:0] ioLive;
  logic [IO_ADDR_W-1:0] rdWord;
  logic [BIT_IDX_W-1:0] rdBit;
  logic [WORD_W-1:0]    rdData;

  always_ff @(posedge clk) begin
    if (cfgWrEn && selE == CFG_IOWORD) ioMem[cfgAddr] <= cfgData[WORD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             ioLive <= '0;
    else if (cfgWrEn && selE == CFG_IOWORD) ioLive[cfgAddr] <= 1'b1;
  end

  assign rdWord = evtCode[PORT_W-1:BIT_IDX_W];
  assign rdBit  = evtCode[BIT_IDX_W-1:0];
  assign rdData = ioMem[rdWord];
  assign ioHit  = ioLive[rdWord] & rdData[rdBit];

  // Control-register shadows
  logic [NUM_SHADOW-1:0][DATA_W-1:0] shadowVec;
  for (genvar i = 0; i < NUM_SHADOW; i++) begin : g_shadow
    logic [DATA_W-1:0] shQ;
    always_ff @(posedge clk) begin
      if (!rst_n)                                      shQ <= '0;
      else if (cfgWrEn && cfgSel == 3'(SH_BASE + i))   shQ <= cfgData;
    end
    assign shadowVec[i] = shQ;
  end

  // Timestamp offset
  logic [DATA_W-1:0] tscOfs;
  always_ff @(posedge clk) begin
    if (!rst_n)                              tscOfs <= '0;
    else if (cfgWrEn && selE == CFG_TSCOFS)  tscOfs <= cfgData;
  end

  // Result selection
  logic [DATA_W-1:0] shadowSel;
  logic [DATA_W-1:0] dataNext;
  always_comb begin
    unique case (strobe.shIdx)
      2'd0:    shadowSel = shadowVec[0];
      2'd1:    shadowSel = shadowVec[1];
      2'd2:    shadowSel = shadowVec[2];
      default: shadowSel = '0;
    endcase
    unique case (strobe.dataSel)
      DSEL_SHADOW: dataNext = shadowSel;
      DSEL_TSC:    dataNext = evtTsc + tscOfs;
      default:     dataNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !strobe.load) begin
      resValid   <= 1'b0;
      resExit    <= 1'b0;
      resReason  <= '0;
      resCode    <= '0;
      resDeliver <= 1'b0;
      resData    <= '0;
    end else begin
      resValid   <= 1'b1;
      resExit    <= strobe.doExit;
      resReason  <= strobe.doExit ? strobe.reason : 3'd0;
      resCode    <= evtCode;
      resDeliver <= strobe.deliver;
      resData    <= strobe.doExit ? '0 : dataNext;
    end
  end

  // R11
  exit_deliver_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(resExit && resDeliver));

  // R11
  exit_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resExit |-> resData == '0);

endmodule

// File: rtl/gevt_exit_filter.sv
module gevt_exit_filter
  import gevt_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int PORT_W = 16,
  parameter int VEC_W  = 5,
  parameter int WORD_W = 32,
  localparam int IO_ADDR_W = PORT_W - $clog2(WORD_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfgWrEn,
  input  logic [2:0]           cfgSel,
  input  logic [IO_ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0]    cfgData,
  input  logic                 evtValid,
  input  logic [2:0]           evtKind,
  input  logic [PORT_W-1:0]    evtCode,
  input  logic [DATA_W-1:0]    evtTsc,
  output logic                 resValid,
  output logic                 resExit,
  output logic [2:0]           resReason,
  output logic [PORT_W-1:0]    resCode,
  output logic                 resDeliver,
  output logic [DATA_W-1:0]    resData
);

  ctrlStrobe_t strobe;
  logic        excHit;
  logic        ioHit;

  gevt_ctrl #(.CODE_W(PORT_W)) u_ctrl (
    .evtValid (evtValid),
    .evtKind  (evtKind),
    .evtCode  (evtCode),
    .excHit   (excHit),
    .ioHit    (ioHit),
    .strobe   (strobe)
  );

  gevt_dp #(
    .DATA_W (DATA_W),
    .PORT_W (PORT_W),
    .VEC_W  (VEC_W),
    .WORD_W (WORD_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfgWrEn    (cfgWrEn),
    .cfgSel     (cfgSel),
    .cfgAddr    (cfgAddr),
    .cfgData    (cfgData),
    .evtCode    (evtCode),
    .evtTsc     (evtTsc),
    .strobe     (strobe),
    .excHit     (excHit),
    .ioHit      (ioHit),
    .resValid   (resValid),
    .resExit    (resExit),
    .resReason  (resReason),
    .resCode    (resCode),
    .resDeliver (resDeliver),
    .resData    (resData)
  );

  // R8
  valid_follows_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evtValid |=> resValid);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evtValid |=> (!resValid && !resExit && !resDeliver && resData == '0));

  // R6
  syscall_no_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evtValid && evtKind == 3'(EV_SYSCALL)) |=> (!resExit && !resDeliver));

  // R7
  intr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evtValid && evtKind == 3'(EV_EXTINT)) |=> (resExit && resReason == 3'(RSN_INTR)));

  // R5
  tsc_no_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evtValid && evtKind == 3'(EV_TSC)) |=> !resExit);

  // R10
  code_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evtValid |=> resCode == $past(evtCode));

endmodule

// File: tb/gevt_exit_filter_tb.sv
module gevt_exit_filter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [10:0] cfgAddr = '0;
  logic [63:0] cfgData = '0;
  logic        evtValid = 1'b0;
  logic [2:0]  evtKind = '0;
  logic [15:0] evtCode = '0;
  logic [63:0] evtTsc = '0;
  logic        resValid, resExit, resDeliver;
  logic [2:0]  resReason;
  logic [15:0] resCode;
  logic [63:0] resData;

  always #5 clk = ~clk;

  gevt_exit_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .evtValid(evtValid),
    .evtKind(evtKind), .evtCode(evtCode), .evtTsc(evtTsc),
    .resValid(resValid), .resExit(resExit), .resReason(resReason),
    .resCode(resCode), .resDeliver(resDeliver), .resData(resData)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural model state
  bit [31:0] excM = '0;
  bit [31:0] ioM [int];
  bit [63:0] shM [3];
  bit [63:0] ofsM = '0;

  // Expected outputs for the next sample
  logic xV, xE, xD;
  logic [2:0]  xR;
  logic [15:0] xC;
  logic [63:0] xData;
  string xReq;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    cfgWrEn = 0; cfgSel = '0; cfgAddr = '0; cfgData = '0;
    evtValid = 0; evtKind = '0; evtCode = '0; evtTsc = '0;
  endtask

  task automatic tick();
    int w;
    xV = evtValid; xE = 0; xD = 0; xR = 0; xData = 0; xReq = "R8";
    xC = evtValid ? evtCode : 16'h0;
    if (evtValid) begin
      case (evtKind)
        3'd0: begin xReq = "R2"; if (excM[evtCode[4:0]]) xE = 1; else xD = 1; end
        3'd1: begin xReq = "R7"; xE = 1; xR = 1; end
        3'd2: begin
          xReq = "R3"; w = int'(evtCode >> 5);
          if (ioM.exists(w) && ioM[w][evtCode[4:0]]) begin xE = 1; xR = 2; end
        end
        3'd3: begin
          xReq = "R4";
          if (evtCode == 0) xData = shM[0];
          else if (evtCode == 2) xData = shM[1];
          else if (evtCode == 4) xData = shM[2];
          else begin xE = 1; xR = 4; end
        end
        3'd4: begin xReq = "R7"; xE = 1; xR = 3; end
        3'd5: begin xReq = "R5"; xData = evtTsc + ofsM; end
        3'd6: begin xReq = "R6"; end
        default: begin xReq = "R7"; xE = 1; xR = 4; end
      endcase
    end
    // R9: model takes the write only after this event's expectation
    if (cfgWrEn) begin
      case (cfgSel)
        3'd0: excM = cfgData[31:0];
        3'd1: ioM[int'(cfgAddr)] = cfgData[31:0];
        3'd2: shM[0] = cfgData;
        3'd3: shM[1] = cfgData;
        3'd4: shM[2] = cfgData;
        3'd5: ofsM = cfgData;
        default: ;
      endcase
    end
    @(negedge clk);
    chk(xReq, "resValid", 64'(resValid), 64'(xV));
    chk(xReq, "resExit", 64'(resExit), 64'(xE));
    chk(xReq, "resReason", 64'(resReason), 64'(xR));
    chk(xReq, "resDeliver", 64'(resDeliver), 64'(xD));
    chk(xReq, "resData", resData, xData);
    chk("R10", "resCode", 64'(resCode), 64'(xC));
    chk("R11", "exit_and_deliver", 64'(resExit & resDeliver), 64'(0));
    idle();
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [10:0] addr, input logic [63:0] data);
    cfgWrEn = 1; cfgSel = sel; cfgAddr = addr; cfgData = data;
    tick();
  endtask

  task automatic ev(input logic [2:0] kind, input logic [15:0] code, input logic [63:0] tsc);
    evtValid = 1; evtKind = kind; evtCode = code; evtTsc = tsc;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    shM[0] = 0; shM[1] = 0; shM[2] = 0;
    // R1: outputs quiet while in reset
    repeat (3) @(negedge clk);
    chk("R1", "reset resValid", 64'(resValid), 0);
    chk("R1", "reset resExit", 64'(resExit), 0);
    chk("R1", "reset resData", resData, 0);
    rst_n = 1;
    tick();
    // R1: cleared bitmaps, zero shadows and offset
    ev(3'd0, 16'd14, 0);
    ev(3'd2, 16'h03F8, 0);
    ev(3'd2, 16'hFFFF, 0);
    ev(3'd3, 16'd0, 0);
    ev(3'd3, 16'd4, 0);
    ev(3'd5, 16'd0, 64'd1234);

    // R2: exception bitmap vectors 0, 14, 31
    cfg(3'd0, 0, 64'h8000_4001);
    ev(3'd0, 16'd0, 0);
    ev(3'd0, 16'd1, 0);
    ev(3'd0, 16'd14, 0);
    ev(3'd0, 16'd30, 0);
    ev(3'd0, 16'd31, 0);

    // R3: ports 0x3F8, 0xFFFF, 0x0000
    cfg(3'd1, 11'd31, 64'h0100_0000);
    cfg(3'd1, 11'd2047, 64'h8000_0000);
    cfg(3'd1, 11'd0, 64'h1);
    ev(3'd2, 16'h03F8, 0);
    ev(3'd2, 16'h03F9, 0);
    ev(3'd2, 16'hFFFF, 0);
    ev(3'd2, 16'hFFFE, 0);
    ev(3'd2, 16'h0000, 0);
    ev(3'd2, 16'h0001, 0);
    ev(3'd2, 16'h0020, 0);

    // R4: shadows
    cfg(3'd2, 0, 64'h8000_0001);
    cfg(3'd3, 0, 64'hDEAD_BEEF_0000_1000);
    cfg(3'd4, 0, 64'h20);
    ev(3'd3, 16'd0, 0);
    ev(3'd3, 16'd2, 0);
    ev(3'd3, 16'd4, 0);
    ev(3'd3, 16'd3, 0);
    ev(3'd3, 16'd8, 0);

    // R5: offset with wraparound
    cfg(3'd5, 0, 64'hFFFF_FFFF_FFFF_FF00);
    ev(3'd5, 16'd0, 64'h200);
    ev(3'd5, 16'd0, 64'h5);

    // R6, R7
    ev(3'd6, 16'd0, 0);
    ev(3'd6, 16'd1, 0);
    ev(3'd1, 16'd32, 0);
    ev(3'd4, 16'd0, 0);
    ev(3'd7, 16'd9, 0);

    // R9: same-cycle write sees the old bitmap
    cfgWrEn = 1; cfgSel = 3'd0; cfgData = 64'h0000_0020;
    evtValid = 1; evtKind = 3'd0; evtCode = 16'd5;
    tick();
    ev(3'd0, 16'd5, 0);
    cfgWrEn = 1; cfgSel = 3'd2; cfgData = 64'h11;
    evtValid = 1; evtKind = 3'd3; evtCode = 16'd0;
    tick();
    ev(3'd3, 16'd0, 0);

    // Random mix, back-to-back
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        cfgWrEn = 1;
        cfgSel  = 3'($urandom_range(0, 5));
        cfgAddr = 11'($urandom_range(0, 3));
        cfgData = {$urandom, $urandom};
      end
      if ($urandom_range(0, 4) != 0) begin
        evtValid = 1;
        evtKind  = 3'($urandom_range(0, 7));
        evtCode  = (evtKind == 3'd3) ? 16'($urandom_range(0, 5)) :
                   (evtKind == 3'd2) ? 16'($urandom_range(0, 127)) :
                   16'($urandom_range(0, 31));
        evtTsc   = {$urandom, $urandom};
      end
      tick();
    end
    tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule